// File: doc/BRIEF.md
# Byte-Wide CRC Register Window

This block is a CRC engine reached over a simple 8-bit write/read strobe interface. Four byte-wide data registers sit in one window. Together they hold the 32-bit CRC state. Software uses them to load a seed, to push message bytes and to read the checksum back. The `seed_load` input sets what a write means. When it is high, a write replaces one byte of the state. When it is low, only the last register takes writes, and each byte written there is folded into the CRC.

The `wide_mode` input selects the CRC width. In 32-bit mode the whole state is updated with the 32-bit polynomial. In 16-bit mode only the low half is updated, with the 16-bit polynomial, and the upper two registers keep whatever seed bytes were written to them. Each byte is absorbed in one clock cycle. Reads are combinational, so the new value is visible in the cycle after the write.

Top module: `crc_byte_regs`

## Requirements
- R1: After synchronous reset, all four registers read 0xFF, so the state is all ones.
- R2: With `seed_load`=1, a write to offset k loads `wr_data` into one byte of the state. Offset 0 maps to bits 31:24, offset 1 to bits 23:16, offset 2 to bits 15:8 and offset 3 to bits 7:0.
- R3: With `seed_load`=0, writes to offsets 0, 1 and 2 leave the state unchanged.
- R4: With `seed_load`=0 and `wide_mode`=1, a write to offset 3 advances the 32-bit state by one byte. The update uses polynomial 0x04C11DB7, MSB first: the byte is XORed into bits 31:24 and eight shift steps follow. There is no reflection and no final XOR.
- R5: With `seed_load`=0 and `wide_mode`=0, a write to offset 3 advances bits 15:0 with polynomial 0x1021 in the same MSB-first way, the byte going into bits 15:8. Bits 31:16 are not changed.
- R6: While `rd_en`=1, `rd_data` shows the state byte selected by `addr` in the same cycle, including a value written at the previous clock edge. While `rd_en`=0, `rd_data` is 0x00.
- R7: Changing `wide_mode` or `seed_load` without a write leaves the state unchanged.
- R8: Starting from an all-ones seed, the ASCII bytes "123456789" give 0x0376E6E7 in 32-bit mode and 0x29B1 in the low half in 16-bit mode.
- R9: While `wr_en`=0, the state holds, whatever `addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register offset 0..3 |
| wr_data | input | 8 | Write byte |
| seed_load | input | 1 | 1: writes load the seed; 0: writes feed data |
| wide_mode | input | 1 | 1: 32-bit CRC; 0: 16-bit CRC |
| rd_data | output | 8 | Read byte |

## Verification
A write takes effect at the rising edge where `wr_en` is sampled high. Because the read path is combinational, the result is due on `rd_data` one cycle after the write. The bench drives each write on a falling edge and drops the strobe on the next falling edge. It then sets `addr` and `rd_en` and samples `rd_data` a short delay later, well away from any rising edge. Each per-byte CRC result is checked in the cycle right after its byte, against a bitwise model kept in the bench. Full messages are also checked against the known check values.

// File: rtl/crc_byte_regs_pkg.sv
// Package: shared widths, polynomials and reset value for the CRC register window.
// Assumes a byte-wide bus and a state no wider than 32 bits.
package crc_byte_regs_pkg;
    localparam int BYTE_W     = 8;
    localparam int STATE_W    = 32;
    localparam int NUM_REGS   = STATE_W / BYTE_W;
    localparam int OFF_W      = $clog2(NUM_REGS);
    localparam int NARROW_W   = 16;
    localparam logic [STATE_W-1:0]  POLY_WIDE   = 32'h04C1_1DB7;
    localparam logic [NARROW_W-1:0] POLY_NARROW = 16'h1021;
    localparam logic [STATE_W-1:0]  STATE_RESET = '1;
    localparam logic [OFF_W-1:0]    DATA_OFFSET = OFF_W'(NUM_REGS - 1);

    typedef logic [BYTE_W-1:0]   byte_t;
    typedef logic [STATE_W-1:0]  state_t;
    typedef logic [NUM_REGS-1:0] byte_en_t;
endpackage

// File: rtl/crc_byte_step.sv
// Module: crc_byte_step
// Advances an MSB-first CRC of width WIDTH by one input byte. The byte is
// XORed into the top bits and then shifted one bit per stage. The stages
// are unrolled, so the whole update is combinational.
// Assumes WIDTH >= BYTE_W; no reflection and no output XOR.
module crc_byte_step
    import crc_byte_regs_pkg::*;
#(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] POLY  = '0
) (
    input  logic [WIDTH-1:0] crc_in,
    input  byte_t            data_in,
    output logic [WIDTH-1:0] crc_out
);
    localparam int STAGES = BYTE_W;

    logic [WIDTH-1:0] chain [STAGES+1];

    // Seed the chain with the input byte aligned to the top of the register.
    always_comb begin
        chain[0] = crc_in ^ {data_in, {(WIDTH-BYTE_W){1'b0}}};
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One shift step: shift left and apply the polynomial if the top bit was set.
        always_comb begin
            chain[s+1] = chain[s][WIDTH-1] ? ((chain[s] << 1) ^ POLY)
                                           : (chain[s] << 1);
        end
    end

    assign crc_out = chain[STAGES];
endmodule

// File: rtl/crc_write_decode.sv
// Module: crc_write_decode
// Turns a bus write into either per-byte seed enables or a data strobe,
// depending on the seed-load control. In data mode only the last offset
// is accepted; the other offsets produce no action.
module crc_write_decode
    import crc_byte_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             seed_load,
    input  logic [OFF_W-1:0] addr,
    output byte_en_t         seed_en,
    output logic             data_stb
);
    // Seed enables: one-hot on the addressed byte while seed loading is selected.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_en
        always_comb begin
            seed_en[k] = wr_en && seed_load && (addr == OFF_W'(k));
        end
    end

    // Data strobe: a data-mode write that hits the data offset.
    always_comb begin
        data_stb = wr_en && !seed_load && (addr == DATA_OFFSET);
    end

    // R2: at most one byte of the seed is written per cycle
    p_seed_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seed_en));

    // R3: seed loading and data feeding never happen together
    p_mode_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_stb && (|seed_en)));
endmodule

// File: rtl/crc_state_reg.sv
// Module: crc_state_reg
// Holds the 32-bit CRC state. It applies seed byte loads and data updates.
// In narrow mode only the low half is rewritten by data.
// Assumes the decode never raises a seed enable and the data strobe in the
// same cycle. Reset is synchronous and active low.
module crc_state_reg
    import crc_byte_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  byte_en_t            seed_en,
    input  logic                data_stb,
    input  logic                wide_mode,
    input  byte_t               wr_data,
    input  state_t              next_wide,
    input  logic [NARROW_W-1:0] next_narrow,
    output state_t              state
);
    state_t state_d;

    // Next-state selection: data update, seed byte merge, or hold.
    always_comb begin
        state_d = state;
        if (data_stb) begin
            if (wide_mode) begin
                state_d = next_wide;
            end else begin
                state_d[NARROW_W-1:0] = next_narrow;
            end
        end else begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (seed_en[k]) begin
                    state_d[(NUM_REGS-1-k)*BYTE_W +: BYTE_W] = wr_data;
                end
            end
        end
    end

    // State register with synchronous active-low reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= STATE_RESET;
        end else begin
            state <= state_d;
        end
    end

    // R9: nothing moves the state without a seed load or a data strobe
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_stb && !(|seed_en)) |=> $stable(state));

    // R5: a narrow data update keeps the upper half
    p_upper_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !wide_mode) |=> $stable(state[STATE_W-1:NARROW_W]));

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
        // R2: a seed enable lands the bus byte in the mapped byte lane
        p_seed_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
            seed_en[k] |=> (state[(NUM_REGS-1-k)*BYTE_W +: BYTE_W] == $past(wr_data)));
    end
endmodule

// File: rtl/crc_byte_regs.sv
// Module: crc_byte_regs (top)
// Byte-wide CRC register window with four data registers. Writes load the
// seed or feed bytes, as the seed-load control selects. Reads return the
// addressed state byte with no delay.
// Assumes one access per cycle and a synchronous active-low reset.
module crc_byte_regs
    import crc_byte_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    input  logic       seed_load,
    input  logic       wide_mode,
    output logic [7:0] rd_data
);
    byte_en_t            seed_en;
    logic                data_stb;
    state_t              state;
    state_t              next_wide;
    logic [NARROW_W-1:0] next_narrow;

    crc_write_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .seed_load (seed_load),
        .addr      (addr),
        .seed_en   (seed_en),
        .data_stb  (data_stb)
    );

    crc_byte_step #(.WIDTH(STATE_W), .POLY(POLY_WIDE)) u_step_wide (
        .crc_in  (state),
        .data_in (wr_data),
        .crc_out (next_wide)
    );

    crc_byte_step #(.WIDTH(NARROW_W), .POLY(POLY_NARROW)) u_step_narrow (
        .crc_in  (state[NARROW_W-1:0]),
        .data_in (wr_data),
        .crc_out (next_narrow)
    );

    crc_state_reg u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .seed_en     (seed_en),
        .data_stb    (data_stb),
        .wide_mode   (wide_mode),
        .wr_data     (wr_data),
        .next_wide   (next_wide),
        .next_narrow (next_narrow),
        .state       (state)
    );

    // Read mux: pick the addressed byte lane; return zero when not reading.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data = state[(NUM_REGS-1-int'(addr))*BYTE_W +: BYTE_W];
        end
    end

    // R3: a data-mode write below the data offset leaves the state alone
    p_ignore_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !seed_load && (addr != DATA_OFFSET)) |=> $stable(state));

    // R6: no read strobe, no read data
    p_quiet_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == 8'h00));
endmodule

// File: tb/crc_byte_regs_tb.sv
// Directed bench for crc_byte_regs: one task per scenario, each checking itself.
module crc_byte_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       seed_load = 1'b0;
    logic       wide_mode = 1'b1;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] model;

    crc_byte_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .seed_load(seed_load), .wide_mode(wide_mode),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref32(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c ^ {b, 24'h0};
        for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    function automatic logic [15:0] ref16(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h0};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_byte(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic check_word(input string req, input logic [31:0] exp);
        logic [7:0] d;
        for (int k = 0; k < 4; k++) begin
            read_byte(2'(k), d);
            check(req, d, exp[(3-k)*8 +: 8]);
        end
    endtask

    task automatic seed_word(input logic [31:0] s);
        seed_load = 1'b1;
        for (int k = 0; k < 4; k++) bus_write(2'(k), s[(3-k)*8 +: 8]);
        seed_load = 1'b0;
    endtask

    task automatic t_reset();
        check_word("R1", 32'hFFFF_FFFF);
    endtask

    task automatic t_seed_map();
        seed_word(32'h1234_5678);
        check_word("R2", 32'h1234_5678);
    endtask

    task automatic t_ignore_low();
        for (int k = 0; k < 3; k++) bus_write(2'(k), 8'hAA);
        check_word("R3", 32'h1234_5678);
    endtask

    task automatic t_idle_hold();
        // R9: bus lines move without a write strobe
        @(negedge clk);
        addr = 2'd3; wr_data = 8'h5C;
        @(negedge clk);
        @(negedge clk);
        check_word("R9", 32'h1234_5678);
    endtask

    task automatic t_read_quiet();
        // R6: read strobe low forces zero
        addr = 2'd1; rd_en = 1'b0;
        #1 check("R6", rd_data, 8'h00);
    endtask

    task automatic t_message32();
        string msg = "123456789";
        logic [7:0] d;
        wide_mode = 1'b1;
        seed_word(32'hFFFF_FFFF);
        model = 32'hFFFF_FFFF;
        for (int i = 0; i < msg.len(); i++) begin
            bus_write(2'd3, msg[i]);
            model = ref32(model, msg[i]);
            read_byte(2'd3, d);
            check("R4", d, model[7:0]);  // R6: due one cycle after the write
            read_byte(2'd0, d);
            check("R4", d, model[31:24]);
        end
        check_word("R8", 32'h0376_E6E7);
    endtask

    task automatic t_message16();
        string msg = "123456789";
        logic [7:0] d;
        logic [15:0] m16;
        wide_mode = 1'b0;
        seed_word(32'hA55A_FFFF);
        m16 = 16'hFFFF;
        for (int i = 0; i < msg.len(); i++) begin
            bus_write(2'd3, msg[i]);
            m16 = ref16(m16, msg[i]);
            read_byte(2'd2, d);
            check("R5", d, m16[15:8]);
        end
        check_word("R8", 32'hA55A_29B1);
        check_word("R5", {16'hA55A, m16});
    endtask

    task automatic t_mode_toggle();
        @(negedge clk); wide_mode = 1'b1;
        @(negedge clk); seed_load = 1'b1;
        @(negedge clk); seed_load = 1'b0; wide_mode = 1'b0;
        @(negedge clk);
        check_word("R7", 32'hA55A_29B1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seed_map();
        t_ignore_low();
        t_idle_hold();
        t_read_quiet();
        t_message32();
        t_message16();
        t_mode_toggle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule